// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns a pair of already-filtered, clock-synchronous quadrature channels into position steps for a 16-bit counter. A two-bit mode code picks which channel edges produce steps: only channel A edges, only channel B edges, or edges on both channels. Counting on one channel gives twice the line count per revolution, and counting on both gives four times. Code 0 stops counting from the channels.

The counter runs in a ring from 0 up to a programmable reload limit. Stepping up from the limit returns it to 0. Stepping down from 0 loads the limit. A one-cycle wrap pulse marks both cases. A direction flag keeps the sense of the most recent step.

A small phase state machine stores the previous channel levels. It classifies every clock as one of five transitions: prime, hold, channel A edge, channel B edge, or illegal (both channels change at once). The states are INIT (no levels stored yet), LL, LH, HL and HH, where the letters give the stored A and B levels. INIT always takes the prime transition into the state that matches the sampled levels. Every other state takes the transition that compares the stored levels with the new ones, then moves to the state of the new levels.

Top module: `qenc_counter`

## Requirements
- R1: While reset is asserted, `cnt_o` is 0, `dir_dn_o` is 0 and `wrap_o` is 0.
- R2: Mode code 1 (bit 0 set, bit 1 clear) counts only on `ph_a` edges. A step is up when the new `ph_a` level differs from `ph_b`, and down otherwise.
- R3: Mode code 2 (bit 1 set, bit 0 clear) counts only on `ph_b` edges. A step is up when the new `ph_b` level equals `ph_a`, and down otherwise.
- R4: Mode code 3 counts on edges of both channels, with the direction rule of R2 for `ph_a` edges and of R3 for `ph_b` edges.
- R5: Mode code 0 produces no steps. `cnt_o` holds its value and `wrap_o` stays 0 whatever the channels do.
- R6: An up step taken when the count is at or above `reload_val` sets the count to 0 and raises `wrap_o` for that one cycle.
- R7: A down step taken when the count is 0 loads `reload_val` into the count and raises `wrap_o` for that one cycle.
- R8: `dir_dn_o` is 1 after a down step and 0 after an up step. It keeps its value on cycles without a step.
- R9: If both channels change between two samples, no step is taken. The count, the direction flag and the wrap output are unaffected.
- R10: The first clock after reset only records the channel levels. Nonzero levels present at reset release produce no step.
- R11: A channel change sampled at a clock edge appears on `cnt_o`, `dir_dn_o` and `wrap_o` right after that edge. Without a wrap, the count moves by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_mode | input | 2 | Edge selection: 0 off, 1 A only, 2 B only, 3 both |
| reload_val | input | 16 | Upper limit of the count ring |
| ph_a | input | 1 | Filtered channel A level |
| ph_b | input | 1 | Filtered channel B level |
| cnt_o | output | 16 | Current position count |
| dir_dn_o | output | 1 | Direction of the most recent step, 1 = down |
| wrap_o | output | 1 | One-cycle pulse on wrap in either direction |

## Verification
The channels are driven through full Gray-code cycles, forward and backward, in each mode. In mode 1 and mode 2 the half of the edges that must not count separates them from mode 3, and the reversed sequences test each direction rule on its own. Runs past the limit and below zero check both wrap paths, and a reload limit of 0 makes every step wrap. A simultaneous flip of both channels, held levels after steps, mode 0 activity and nonzero channel levels at reset release separate the illegal transition, the direction hold, the disabled mode and the priming state from ordinary steps.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [2:0] {
        PH_INIT = 3'd0,
        PH_LL   = 3'd1,
        PH_LH   = 3'd2,
        PH_HL   = 3'd3,
        PH_HH   = 3'd4
    } phase_t;

    typedef enum logic [2:0] {
        T_PRIME   = 3'd0,
        T_HOLD    = 3'd1,
        T_EDGE_A  = 3'd2,
        T_EDGE_B  = 3'd3,
        T_ILLEGAL = 3'd4
    } trans_t;

    typedef struct packed {
        logic valid;
        logic up;
    } step_t;

    function automatic phase_t levels_to_phase(input logic a, input logic b);
        phase_t p;
        unique case ({a, b})
            2'b00:   p = PH_LL;
            2'b01:   p = PH_LH;
            2'b10:   p = PH_HL;
            default: p = PH_HH;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/qenc_phase_fsm.sv
module qenc_phase_fsm
    import qenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       ch_a,
    input  logic       ch_b,
    output step_t      step,
    output trans_t     trans
);

    phase_t state_q;
    phase_t state_d;
    logic   prev_a;
    logic   prev_b;
    logic   primed;
    logic   edge_a;
    logic   edge_b;

    // next state always mirrors the sampled levels
    always_comb begin
        state_d = levels_to_phase(ch_a, ch_b);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    // decode stored levels
    always_comb begin
        prev_a = 1'b0;
        prev_b = 1'b0;
        primed = 1'b1;
        unique case (state_q)
            PH_INIT: primed = 1'b0;
            PH_LL:   ;
            PH_LH:   prev_b = 1'b1;
            PH_HL:   prev_a = 1'b1;
            PH_HH: begin
                prev_a = 1'b1;
                prev_b = 1'b1;
            end
            default: primed = 1'b0;
        endcase
    end

    assign edge_a = primed & (ch_a ^ prev_a);
    assign edge_b = primed & (ch_b ^ prev_b);

    // transition classification
    always_comb begin
        if (!primed) begin
            trans = T_PRIME;
        end else if (edge_a && edge_b) begin
            trans = T_ILLEGAL;
        end else if (edge_a) begin
            trans = T_EDGE_A;
        end else if (edge_b) begin
            trans = T_EDGE_B;
        end else begin
            trans = T_HOLD;
        end
    end

    // output process: step request per transition and mode
    always_comb begin
        step = '0;
        unique case (trans)
            T_EDGE_A: begin
                step.valid = mode[0];
                step.up    = ch_a ^ ch_b;
            end
            T_EDGE_B: begin
                step.valid = mode[1];
                step.up    = ~(ch_a ^ ch_b);
            end
            T_PRIME, T_HOLD, T_ILLEGAL: step = '0;
            default:                    step = '0;
        endcase
    end

endmodule

// File: rtl/qenc_wrap_counter.sv
module qenc_wrap_counter
    import qenc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  step_t         step,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count,
    output logic          dir_dn,
    output logic          wrap
);

    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] ONE  = CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= ZERO;
            dir_dn <= 1'b0;
            wrap   <= 1'b0;
        end else if (step.valid) begin
            if (step.up) begin
                dir_dn <= 1'b0;
                if (count >= limit) begin
                    count <= ZERO;
                    wrap  <= 1'b1;
                end else begin
                    count <= count + ONE;
                    wrap  <= 1'b0;
                end
            end else begin
                dir_dn <= 1'b1;
                if (count == ZERO) begin
                    count <= limit;
                    wrap  <= 1'b1;
                end else begin
                    count <= count - ONE;
                    wrap  <= 1'b0;
                end
            end
        end else begin
            wrap <= 1'b0;
        end
    end

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       enc_mode,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             ph_a,
    input  logic             ph_b,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_dn_o,
    output logic             wrap_o
);

    step_t  step_w;
    trans_t trans_w;

    qenc_phase_fsm u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (enc_mode),
        .ch_a  (ph_a),
        .ch_b  (ph_b),
        .step  (step_w),
        .trans (trans_w)
    );

    qenc_wrap_counter #(
        .CW (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step_w),
        .limit  (reload_val),
        .count  (cnt_o),
        .dir_dn (dir_dn_o),
        .wrap   (wrap_o)
    );

endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   enc_mode,
    input logic [W-1:0] reload_val,
    input logic         ph_a,
    input logic         ph_b,
    input logic [W-1:0] cnt_o,
    input logic         dir_dn_o,
    input logic         wrap_o
);

    localparam logic [W-1:0] ONE = W'(1);

    assert_mode_off_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_mode == 2'd0) |=> ($stable(cnt_o) && !wrap_o));

    assert_wrap_up_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !dir_dn_o) |-> (cnt_o == '0));

    assert_wrap_dn_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && dir_dn_o) |-> (cnt_o == $past(reload_val)));

    assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_o && (cnt_o == $past(cnt_o))) |-> $stable(dir_dn_o));

    assert_unit_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |-> ((cnt_o == $past(cnt_o)) ||
                     (cnt_o == $past(cnt_o) + ONE) ||
                     (cnt_o == $past(cnt_o) - ONE)));

    // R9: both channels flipping between samples leaves the outputs alone
    assert_illegal_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph_a != $past(ph_a)) && (ph_b != $past(ph_b)) && $past(rst_n))
        |=> ($stable(cnt_o) && !wrap_o));

endmodule

bind qenc_counter qenc_checker #(.W(CNT_W)) u_qenc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enc_mode   (enc_mode),
    .reload_val (reload_val),
    .ph_a       (ph_a),
    .ph_b       (ph_b),
    .cnt_o      (cnt_o),
    .dir_dn_o   (dir_dn_o),
    .wrap_o     (wrap_o)
);

// File: tb/qenc_counter_bench.sv
`timescale 1ns/1ps
module qenc_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  enc_mode = 2'd0;
    logic [15:0] reload_val = 16'd0;
    logic        ph_a = 1'b0;
    logic        ph_b = 1'b0;
    logic [15:0] cnt_o;
    logic        dir_dn_o;
    logic        wrap_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    qenc_counter u_qenc_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .enc_mode   (enc_mode),
        .reload_val (reload_val),
        .ph_a       (ph_a),
        .ph_b       (ph_b),
        .cnt_o      (cnt_o),
        .dir_dn_o   (dir_dn_o),
        .wrap_o     (wrap_o)
    );

    // expected queues
    logic [15:0] q_cnt[$];
    logic        q_dir[$];
    logic        q_wrap[$];
    string       q_tag[$];

    // reference model state
    logic [1:0]  m_mode = 2'd1;
    logic [15:0] m_lim = 16'd5;
    logic [15:0] m_cnt = 16'd0;
    logic        m_dir = 1'b0;
    logic        m_pa = 1'b0;
    logic        m_pb = 1'b0;

    task automatic apply(input logic a, input logic b, input string tag);
        logic ea, eb, sv, up, wr;
        @(negedge clk);
        enc_mode   = m_mode;
        reload_val = m_lim;
        ph_a = a;
        ph_b = b;
        ea = (a != m_pa);
        eb = (b != m_pb);
        sv = 1'b0;
        up = 1'b0;
        wr = 1'b0;
        if (!(ea && eb)) begin
            if (ea && m_mode[0]) begin
                sv = 1'b1;
                up = (a != b);
            end else if (eb && m_mode[1]) begin
                sv = 1'b1;
                up = (a == b);
            end
        end
        if (sv) begin
            if (up) begin
                m_dir = 1'b0;
                if (m_cnt >= m_lim) begin m_cnt = 16'd0; wr = 1'b1; end
                else m_cnt = m_cnt + 16'd1;
            end else begin
                m_dir = 1'b1;
                if (m_cnt == 16'd0) begin m_cnt = m_lim; wr = 1'b1; end
                else m_cnt = m_cnt - 16'd1;
            end
        end
        m_pa = a;
        m_pb = b;
        q_cnt.push_back(m_cnt);
        q_dir.push_back(m_dir);
        q_wrap.push_back(wr);
        q_tag.push_back(tag);
    endtask

    // forward Gray order: 00 -> 10 -> 11 -> 01 -> 00
    task automatic fwd(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            case ({m_pa, m_pb})
                2'b00:   apply(1'b1, 1'b0, tag);
                2'b10:   apply(1'b1, 1'b1, tag);
                2'b11:   apply(1'b0, 1'b1, tag);
                default: apply(1'b0, 1'b0, tag);
            endcase
        end
    endtask

    task automatic rev(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            case ({m_pa, m_pb})
                2'b00:   apply(1'b0, 1'b1, tag);
                2'b01:   apply(1'b1, 1'b1, tag);
                2'b11:   apply(1'b1, 1'b0, tag);
                default: apply(1'b0, 1'b0, tag);
            endcase
        end
    endtask

    // monitor: pops one expected item per cycle after the edge settles
    always begin
        @(posedge clk);
        #1;
        if (rst_n && q_cnt.size() > 0) begin
            logic [15:0] ec;
            logic ed, ew;
            string t;
            ec = q_cnt.pop_front();
            ed = q_dir.pop_front();
            ew = q_wrap.pop_front();
            t  = q_tag.pop_front();
            total++;
            if (cnt_o !== ec || dir_dn_o !== ed || wrap_o !== ew) begin
                bad++;
                $display("FAIL %s: cnt=%0d dir=%0b wrap=%0b expected cnt=%0d dir=%0b wrap=%0b",
                         t, cnt_o, dir_dn_o, wrap_o, ec, ed, ew);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 / R10 setup: nonzero levels during reset
        enc_mode   = 2'd1;
        reload_val = 16'd5;
        ph_a = 1'b1;
        ph_b = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        total++;
        if (cnt_o !== 16'd0 || dir_dn_o !== 1'b0 || wrap_o !== 1'b0) begin
            bad++;
            $display("FAIL R1: cnt=%0d dir=%0b wrap=%0b expected cnt=0 dir=0 wrap=0",
                     cnt_o, dir_dn_o, wrap_o);
        end
        m_pa = 1'b1;
        m_pb = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply(1'b1, 1'b0, "R10");
        apply(1'b1, 1'b0, "R10");

        // mode 1 forward, past the limit
        m_mode = 2'd1;
        fwd(12, "R2_R6");
        // mode 1 reverse, below zero
        rev(14, "R2_R7");
        // direction held while idle
        apply(m_pa, m_pb, "R8");
        apply(m_pa, m_pb, "R8");

        // mode 2
        m_mode = 2'd2;
        fwd(8, "R3");
        rev(6, "R3");

        // mode 3
        m_mode = 2'd3;
        m_lim  = 16'd9;
        fwd(10, "R4");
        rev(13, "R4_R7");
        apply(m_pa, m_pb, "R8");

        // mode 0
        m_mode = 2'd0;
        fwd(6, "R5");
        rev(3, "R5");

        // simultaneous change
        m_mode = 2'd3;
        apply(~m_pa, ~m_pb, "R9");
        apply(~m_pa, ~m_pb, "R9");
        fwd(2, "R9");

        // limit 0: every step wraps
        m_lim = 16'd0;
        fwd(3, "R6");
        rev(3, "R7");

        // large limit, one-per-cycle steps
        m_lim = 16'd1000;
        fwd(20, "R11");
        rev(25, "R11");

        while (q_cnt.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule